// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block moves 8-bit characters over a four-wire serial link. It can act as the side that drives the clock (host) or as the side that follows it (client). The idle level of SCK, the edge on which data is sampled and the bit order are set by static configuration inputs. In host mode each accepted character is sent in its own select-low frame. SCK runs at the system clock divided by a programmable half-period count. In client mode the engine follows an external SCK and select line through input synchronisers. It can optionally treat the first byte of every frame as an address to be matched.

Received characters go to a one-entry holding buffer that is read through a valid/ready handshake. If a character completes while the buffer is still full, the new character is lost. The engine then reports the loss with a one-cycle pulse, either at once or when the held character is read, depending on a configuration input. A standby request stops the engine: a client stops at once, while a host first completes the character on the wire. A configuration input can make the engine ignore standby requests altogether.

Top module: `spi_xfer_core`

## Requirements
- R1: With `cfg_lsb_first`=0 bit 7 of a character is on the wire first; with 1, bit 0 goes first, in both directions.
- R2: SCK rests at the level of `cfg_cpol` when no frame is active; the leading edge is the move away from that level.
- R3: With `cfg_cpha`=0 incoming data is captured on leading edges and outgoing data changes on trailing edges; with 1 the roles of the two edges swap.
- R4: In host mode a character accepted on `tx_valid`/`tx_ready` drives `ss_n_o` low. Sixteen SCK edges follow, each `cfg_baud`+1 clock cycles apart. Data goes out on MOSI, and the character read from MISO is delivered to the receive buffer.
- R5: In client mode the frame lasts while `ss_n_i` is low, data in is MOSI and data out is MISO. A transmit character is taken at frame start and after each completed character. When `tx_valid` is low at that point, zeros are shifted out.
- R6: With `cfg_addr_mode`=1 the client compares the first character of each frame with `cfg_addr`. That character is never delivered, and on a match the following characters of the frame are delivered.
- R7: When the address does not match, the remaining characters of that frame are not delivered.
- R8: A delivered character stays on `rx_data` with `rx_valid` high until read. A character completing while the buffer is full and not being read is discarded.
- R9: With `cfg_ovf_immediate`=1, `rx_ovf` pulses one cycle after each discarded character completes.
- R10: With `cfg_ovf_immediate`=0 a discard produces no pulse until the held character is read; `rx_ovf` then pulses once in the cycle after that read.
- R11: A client with `cfg_run_standby`=0 aborts its frame as soon as `standby_req` rises. It drives MISO low, raises `halted` and delivers nothing until the request falls and a new frame begins.
- R12: A host with `cfg_run_standby`=0 completes the character in progress when `standby_req` rises. It then raises `halted` and starts no new frame while the request stays high.
- R13: With `cfg_run_standby`=1, `standby_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_host | input | 1 | 1 = host, 0 = client |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_addr_mode | input | 1 | Client address-match frames |
| cfg_addr | input | 8 | Address compared with the first client byte |
| cfg_ovf_immediate | input | 1 | Overflow pulse timing select |
| cfg_run_standby | input | 1 | Keep running during standby |
| cfg_baud | input | DIVW | Host SCK half period minus one, in clocks |
| standby_req | input | 1 | Standby request |
| halted | output | 1 | Engine stopped by standby |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmit character taken this cycle |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Receive buffer read |
| rx_ovf | output | 1 | Overflow pulse |
| sck_o | output | 1 | Host SCK |
| ss_n_o | output | 1 | Host select, active low |
| mosi_o | output | 1 | Host data out |
| miso_i | input | 1 | Host data in |
| sck_i | input | 1 | Client SCK |
| ss_n_i | input | 1 | Client select, active low |
| mosi_i | input | 1 | Client data in |
| miso_o | output | 1 | Client data out |

## Verification
A bit counter that is off by one shows at the ports within a single character: the received byte comes out shifted, or the host produces a wrong number of SCK edges before releasing select. A wrong frame state in the client, such as a stale address flag or a drop flag that never clears, appears as missing or extra deliveries in the very next frame. A lost or stuck overflow pending state shows as an absent or extra `rx_ovf` pulse at the first read after a discard. Standby errors are visible within a few cycles on `halted`, `ss_n_o` and MISO.

// File: rtl/spi_xfer_core.sv
module spi_xfer_core #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_host,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_lsb_first,
  input  logic            cfg_addr_mode,
  input  logic [7:0]      cfg_addr,
  input  logic            cfg_ovf_immediate,
  input  logic            cfg_run_standby,
  input  logic [DIVW-1:0] cfg_baud,
  input  logic            standby_req,
  output logic            halted,
  input  logic [7:0]      tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [7:0]      rx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic            rx_ovf,
  output logic            sck_o,
  output logic            ss_n_o,
  output logic            mosi_o,
  input  logic            miso_i,
  input  logic            sck_i,
  input  logic            ss_n_i,
  input  logic            mosi_i,
  output logic            miso_o
);

  localparam int NB = 8;
  localparam int CW = $clog2(NB);
  localparam int TW = $clog2(2*NB+2);

  // client-side synchronisers
  logic [2:0] sck_s, ss_s;
  logic [1:0] mosi_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0; ss_s <= '1; mosi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ss_s <= {ss_s[1:0], ss_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
    end

  wire stop_req = standby_req & ~cfg_run_standby;
  wire c_rise = sck_s[1] & ~sck_s[2];
  wire c_fall = ~sck_s[1] & sck_s[2];
  wire c_start = ~cfg_host & ~stop_req & ~halted & ~ss_s[1] & ss_s[2];

  logic c_act, c_first, c_drop;
  wire c_live = c_act & ~ss_s[1];
  wire c_lead = c_live & (cfg_cpol ? c_fall : c_rise);
  wire c_trail = c_live & (cfg_cpol ? c_rise : c_fall);

  // host clock generator
  logic            h_busy, sck_q, ss_q;
  logic [DIVW-1:0] h_div;
  logic [TW-1:0]   h_tog;
  wire h_tick = h_busy && (h_div == cfg_baud);
  wire h_edge = h_tick && (h_tog != '0) && (h_tog <= TW'(2*NB));
  wire h_end = h_tick && (h_tog == TW'(2*NB+1));
  wire h_lead = h_edge && (sck_q == cfg_cpol);
  wire h_trail = h_edge && (sck_q != cfg_cpol);

  // shared shift datapath
  logic [CW-1:0] cnt;
  logic [7:0]    sh, rsh;
  wire lead = cfg_host ? h_lead : c_lead;
  wire trail = cfg_host ? h_trail : c_trail;
  wire smp = cfg_cpha ? trail : lead;
  wire shf = cfg_cpha ? lead : trail;
  wire din = cfg_host ? miso_i : mosi_s[1];
  wire [7:0] rnext = cfg_lsb_first ? {din, rsh[7:1]} : {rsh[6:0], din};
  wire done = smp && (cnt == CW'(NB-1));
  wire c_load = c_start | (c_live & done);
  wire dout = cfg_lsb_first ? sh[0] : sh[NB-1];

  assign tx_ready = cfg_host ? (~h_busy & ~halted & ~stop_req) : c_load;
  wire h_start = cfg_host & tx_valid & tx_ready;
  wire load = h_start | c_load;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_busy <= 1'b0; h_div <= '0; h_tog <= '0; sck_q <= 1'b0; ss_q <= 1'b1;
    end else begin
      if (h_start) begin
        h_busy <= 1'b1; h_div <= '0; h_tog <= '0; ss_q <= 1'b0;
      end else if (h_busy) begin
        if (h_tick) begin
          h_div <= '0;
          h_tog <= h_tog + 1'b1;
        end else h_div <= h_div + 1'b1;
        if (h_end) begin
          h_busy <= 1'b0; ss_q <= 1'b1;
        end
      end
      if (!h_busy) sck_q <= cfg_cpol;
      else if (h_edge) sck_q <= ~sck_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sh <= '0; rsh <= '0;
    end else begin
      if (h_start | c_start | done) cnt <= '0;
      else if (smp) cnt <= cnt + 1'b1;
      if (load) sh <= tx_valid ? tx_data : 8'h00;
      else if (shf && cnt != '0) sh <= cfg_lsb_first ? {1'b0, sh[7:1]} : {sh[6:0], 1'b0};
      if (smp) rsh <= rnext;
    end

  // client frame tracking
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_act <= 1'b0; c_first <= 1'b0; c_drop <= 1'b0;
    end else begin
      if (cfg_host | stop_req | ss_s[1]) c_act <= 1'b0;
      else if (c_start) c_act <= 1'b1;
      if (c_start) begin
        c_first <= 1'b1; c_drop <= 1'b0;
      end else if (c_live & done) begin
        c_first <= 1'b0;
        if (cfg_addr_mode && c_first && rnext != cfg_addr) c_drop <= 1'b1;
      end
    end

  // receive buffer and overflow
  wire deliver = done & (cfg_host | (c_live & ~c_drop & ~(cfg_addr_mode & c_first)));
  wire rd = rx_valid & rx_ready;
  wire ovf_ev = deliver & rx_valid & ~rx_ready;
  logic ovf_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0; rx_valid <= 1'b0; ovf_pend <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      if (deliver & ~ovf_ev) begin
        rx_data <= rnext; rx_valid <= 1'b1;
      end else if (rd) rx_valid <= 1'b0;
      if (ovf_ev & ~cfg_ovf_immediate) ovf_pend <= 1'b1;
      else if (rd) ovf_pend <= 1'b0;
      rx_ovf <= (ovf_ev & cfg_ovf_immediate) | (rd & ovf_pend & ~cfg_ovf_immediate);
    end

  // standby
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) halted <= 1'b0;
    else if (!stop_req) halted <= 1'b0;
    else if (!cfg_host || !h_busy || h_end) halted <= 1'b1;

  assign sck_o = cfg_host ? sck_q : cfg_cpol;
  assign ss_n_o = ss_q;
  assign mosi_o = cfg_host & dout;
  assign miso_o = c_live & dout;

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_host && ss_n_o) |=> (!cfg_host || !ss_n_o || sck_o == $past(cfg_cpol)));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_ovf_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_ovf_immediate) && rx_ovf) |-> $past(rx_valid && !rx_ready));

  p_ovf_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_ovf_immediate) && rx_ovf) |-> $past(rx_valid && rx_ready));

  p_client_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_host && halted) |-> !miso_o);

  p_host_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_host && halted && $past(halted)) |-> ss_n_o);

endmodule

// File: tb/test_spi_xfer_core.sv
module test_spi_xfer_core;
  logic clk = 0, rst_n = 0;
  logic cfg_host = 1, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_addr_mode = 0;
  logic [7:0] cfg_addr = 8'h5A;
  logic cfg_ovf_immediate = 1, cfg_run_standby = 0;
  logic [7:0] cfg_baud = 8'd1;
  logic standby_req = 0;
  logic halted;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 1, rx_ovf;
  logic sck_o, ss_n_o, mosi_o, miso_i;
  logic sck_i = 0, ss_n_i = 1, mosi_i = 0, miso_o;

  always #5 clk = ~clk;
  assign miso_i = mosi_o;

  spi_xfer_core #(.DIVW(8)) i_spi_xfer_core (
    .clk, .rst_n, .cfg_host, .cfg_cpol, .cfg_cpha, .cfg_lsb_first, .cfg_addr_mode,
    .cfg_addr, .cfg_ovf_immediate, .cfg_run_standby, .cfg_baud, .standby_req, .halted,
    .tx_data, .tx_valid, .tx_ready, .rx_data, .rx_valid, .rx_ready, .rx_ovf,
    .sck_o, .ss_n_o, .mosi_o, .miso_i, .sck_i, .ss_n_i, .mosi_i, .miso_o);

  int ntest = 0, nfail = 0;
  int cyc = 0, last_chg = 0, hp_last = 0, rxn = 0, ovfn = 0;
  logic [7:0] cap = 0;
  logic [7:0] rxlog [32];
  logic sck_prev = 0, mlead;
  localparam int H = 8;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cfg_host) begin
      if (sck_o != sck_prev) begin
        mlead = (sck_prev == cfg_cpol);
        if ((cfg_cpha ? !mlead : mlead) && !ss_n_o) cap <= {cap[6:0], mosi_o};
        hp_last <= cyc - last_chg;
        last_chg <= cyc;
      end
      sck_prev <= sck_o;
    end
    if (rx_valid && rx_ready) begin
      rxlog[rxn[4:0]] <= rx_data;
      rxn <= rxn + 1;
    end
    if (rx_ovf) ovfn <= ovfn + 1;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rx(input int n0);
    int t = 0;
    while (rxn == n0 && t < 5000) begin @(negedge clk); t++; end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic m_bits(input logic [7:0] b, input int nb, output logic [7:0] got);
    got = 0;
    for (int i = 0; i < nb; i++) begin
      int idx;
      idx = cfg_lsb_first ? i : 7 - i;
      if (!cfg_cpha) begin
        mosi_i = b[idx]; waitn(H);
        got[idx] = miso_o; sck_i = ~cfg_cpol; waitn(H);
        sck_i = cfg_cpol;
      end else begin
        sck_i = ~cfg_cpol; mosi_i = b[idx]; waitn(H);
        got[idx] = miso_o; sck_i = cfg_cpol; waitn(H);
      end
    end
  endtask

  task automatic f_begin; @(negedge clk); ss_n_i = 0; waitn(H); endtask
  task automatic f_end; waitn(H); ss_n_i = 1; waitn(4*H); endtask

  task automatic set_client(input logic pol, input logic pha, input logic lsb);
    @(negedge clk);
    cfg_host = 0; cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; sck_i = pol;
    waitn(6);
  endtask

  task automatic host_xfer(input logic [7:0] d);
    int n0, t;
    n0 = rxn; t = 0;
    @(negedge clk); tx_data = d; tx_valid = 1;
    while (!tx_ready && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk); tx_valid = 0;
    wait_rx(n0);
    t = 0;
    while (!ss_n_o && t < 1000) begin @(negedge clk); t++; end
    waitn(3);
  endtask

  // {cpol, cpha, lsb_first, baud, data}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'd1, 8'hA5},
    {1'b0, 1'b1, 1'b0, 8'd2, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'd1, 8'h81},
    {1'b1, 1'b1, 1'b1, 8'd3, 8'h6E},
    {1'b0, 1'b0, 1'b1, 8'd0, 8'hF0},
    {1'b1, 1'b1, 1'b0, 8'd4, 8'h1D}
  };

  initial begin
    repeat (2000000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int n0, o0;
    waitn(3); rst_n = 1; waitn(2);
    chk(ss_n_o == 1, "reset select high R4", ss_n_o, 1);
    chk(rx_valid == 0, "reset buffer empty R8", rx_valid, 0);
    chk(halted == 0, "reset not halted R12", halted, 0);
    chk(sck_o == 0, "reset sck idle R2", sck_o, 0);
    chk(tx_ready == 1, "reset host ready R4", tx_ready, 1);

    // host loopback vectors: R1 R2 R3 R4
    foreach (VEC[k]) begin
      logic [7:0] d;
      d = VEC[k][7:0];
      @(negedge clk);
      cfg_cpol = VEC[k][18]; cfg_cpha = VEC[k][17]; cfg_lsb_first = VEC[k][16]; cfg_baud = VEC[k][15:8];
      waitn(3);
      host_xfer(d);
      chk(rxlog[(rxn-1) & 31] == d, "host loopback data R4", rxlog[(rxn-1) & 31], d);
      chk(cap == (cfg_lsb_first ? rev8(d) : d), "wire bit order R1 R3", cap, cfg_lsb_first ? rev8(d) : d);
      chk(hp_last == int'(cfg_baud) + 1, "sck half period R4", hp_last, cfg_baud + 1);
      chk(sck_o == cfg_cpol, "sck idle after frame R2", sck_o, cfg_cpol);
    end

    // client plain frame, mode 0, msb first: R5 R3
    set_client(0, 0, 0);
    n0 = rxn;
    @(negedge clk); tx_data = 8'hA5; tx_valid = 1;
    f_begin; m_bits(8'h3C, 8, got); f_end;
    tx_valid = 0;
    chk(rxn == n0 + 1 && rxlog[n0 & 31] == 8'h3C, "client rx mosi R5", rxlog[n0 & 31], 8'h3C);
    chk(got == 8'hA5, "client tx miso R5", got, 8'hA5);

    // client cpol1 cpha1 lsb first: R1 R2 R3
    set_client(1, 1, 1);
    n0 = rxn;
    @(negedge clk); tx_data = 8'hA5; tx_valid = 1;
    f_begin; m_bits(8'h81, 8, got); f_end;
    tx_valid = 0;
    chk(rxn == n0 + 1 && rxlog[n0 & 31] == 8'h81, "client lsb rx R1", rxlog[n0 & 31], 8'h81);
    chk(got == 8'hA5, "client lsb tx R1 R3", got, 8'hA5);

    // zero fill when nothing offered: R5
    set_client(0, 1, 0);
    f_begin; m_bits(8'h42, 8, got); f_end;
    chk(got == 8'h00, "client zero fill R5", got, 0);

    // address match: R6
    set_client(0, 0, 0);
    cfg_addr_mode = 1;
    n0 = rxn;
    f_begin; m_bits(8'h5A, 8, got); m_bits(8'h11, 8, got); m_bits(8'h22, 8, got); f_end;
    chk(rxn == n0 + 2, "addr match count R6", rxn - n0, 2);
    chk(rxlog[n0 & 31] == 8'h11 && rxlog[(n0+1) & 31] == 8'h22, "addr match data R6", rxlog[n0 & 31], 8'h11);

    // address mismatch: R7
    n0 = rxn;
    f_begin; m_bits(8'h5B, 8, got); m_bits(8'h33, 8, got); f_end;
    chk(rxn == n0, "addr mismatch ignored R7", rxn - n0, 0);
    cfg_addr_mode = 0;

    // immediate overflow: R8 R9
    @(negedge clk); rx_ready = 0; cfg_ovf_immediate = 1;
    o0 = ovfn; n0 = rxn;
    f_begin; m_bits(8'h01, 8, got); m_bits(8'h02, 8, got); m_bits(8'h03, 8, got); f_end;
    chk(rx_valid == 1 && rx_data == 8'h01, "buffer holds first R8", rx_data, 8'h01);
    chk(ovfn == o0 + 2, "immediate ovf pulses R9", ovfn - o0, 2);
    @(negedge clk); rx_ready = 1; @(negedge clk); rx_ready = 0; waitn(3);
    chk(rxn == n0 + 1 && rx_valid == 0, "single read drains R8", rxn - n0, 1);
    chk(ovfn == o0 + 2, "no ovf on read when immediate R9", ovfn - o0, 2);

    // deferred overflow: R10
    cfg_ovf_immediate = 0;
    o0 = ovfn; n0 = rxn;
    f_begin; m_bits(8'h04, 8, got); m_bits(8'h05, 8, got); f_end;
    chk(ovfn == o0, "deferred ovf silent R10", ovfn - o0, 0);
    @(negedge clk); rx_ready = 1; @(negedge clk); rx_ready = 0; waitn(3);
    chk(ovfn == o0 + 1, "deferred ovf at read R10", ovfn - o0, 1);
    chk(rxlog[n0 & 31] == 8'h04, "deferred kept first R8", rxlog[n0 & 31], 8'h04);
    @(negedge clk); rx_ready = 1; cfg_ovf_immediate = 1;

    // client standby abort: R11
    n0 = rxn;
    @(negedge clk); tx_data = 8'hFF; tx_valid = 1;
    f_begin; m_bits(8'hC3, 4, got);
    standby_req = 1; waitn(4);
    chk(halted == 1, "client halts at once R11", halted, 1);
    chk(miso_o == 0, "client miso low R11", miso_o, 0);
    m_bits(8'h00, 4, got); f_end;
    tx_valid = 0;
    chk(rxn == n0, "aborted frame dropped R11", rxn - n0, 0);
    @(negedge clk); standby_req = 0; waitn(4);
    f_begin; m_bits(8'h77, 8, got); f_end;
    chk(rxn == n0 + 1 && rxlog[n0 & 31] == 8'h77, "client resumes R11", rxlog[n0 & 31], 8'h77);

    // run in standby: R13
    cfg_run_standby = 1; n0 = rxn;
    @(negedge clk); standby_req = 1;
    f_begin; m_bits(8'h99, 8, got); f_end;
    chk(halted == 0, "no halt when running R13", halted, 0);
    chk(rxn == n0 + 1 && rxlog[n0 & 31] == 8'h99, "frame kept in standby R13", rxlog[n0 & 31], 8'h99);
    @(negedge clk); standby_req = 0; cfg_run_standby = 0;

    // host standby: R12
    @(negedge clk); cfg_host = 1; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0; cfg_baud = 8'd3;
    waitn(4);
    n0 = rxn;
    @(negedge clk); tx_data = 8'h4B; tx_valid = 1;
    begin int t = 0; while (ss_n_o && t < 100) begin @(negedge clk); t++; end end
    waitn(10); standby_req = 1; waitn(2);
    chk(ss_n_o == 0 && halted == 0, "host keeps frame R12", ss_n_o, 0);
    wait_rx(n0); waitn(10);
    chk(rxlog[n0 & 31] == 8'h4B, "host frame completes R12", rxlog[n0 & 31], 8'h4B);
    chk(halted == 1 && ss_n_o == 1, "host halted after frame R12", {halted, ss_n_o}, 2'b11);
    waitn(100);
    chk(rxn == n0 + 1 && ss_n_o == 1, "host no new frame R12", rxn - n0, 1);
    standby_req = 0;
    begin int t = 0; while (ss_n_o && t < 100) begin @(negedge clk); t++; end end
    tx_valid = 0;
    wait_rx(n0 + 1); waitn(20);
    chk(rxn == n0 + 2 && halted == 0, "host resumes R12", rxn - n0, 2);

    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule